// File: doc/BRIEF.md
# Serial-controlled 8-bit GPIO expander with change interrupt

This block gives a host eight general-purpose pins reached over a two-wire I2C bus, with the block acting as a bus target. A host addresses the block, writes a command byte that selects one of four per-pin registers, and then writes or reads data bytes. Each pin is set to input or output on its own. A pin set to output drives the value held in the output register. A pin set to input is released. Its sampled level is reported through the input register, and a per-bit inversion mask can flip that level bit by bit.

The 7-bit target address joins a fixed upper part, which is a build parameter, to three strap inputs. Up to eight copies built with the same parameter can therefore share one bus, and a second build with a different fixed part doubles that count. An open-drain, active-low interrupt output pulls the line low whenever a pin configured as input no longer matches the level captured when the input register was last read. The interrupt releases when the host reads the input register, or when the pins return to the captured levels.

The bus lines and the pins are synchronised to the system clock inside the block. SDA is modelled as a pull-down enable, `sda_oe`, and the pins are modelled as separate data and enable signals.

Top module: `i2c_gpio_xp`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` = 0x00), `sda_oe` and `irq_oe` are 0, the output register reads 0xFF, the inversion register reads 0x00 and the direction register reads 0xFF.
- R2: The block acknowledges an address byte only when bits 7..1 equal {ADDR_HI, strap}, with bit 0 giving the direction (1 = read). With any other address it leaves SDA released and changes no register.
- R3: The low two bits of the command byte select the register: 0 = input, 1 = output, 2 = inversion, 3 = direction. The selection persists across transfers, and every data byte of one transfer uses the same register.
- R4: Bit i of the direction register set to 1 makes pin i an input (`pin_oe[i]` = 0), and 0 makes it an output. `pin_o` always carries the output register, and `pin_oe` changes only after a write to register 3.
- R5: Reading register 0 returns the synchronised pin levels XOR the inversion register.
- R6: A write to register 0 is acknowledged but changes no register and no pin output.
- R7: `irq_oe` rises only after a change of an input-configured pin (or of the direction register). A change on an output-configured pin does not raise it.
- R8: `irq_oe` falls within two cycles after the input register is loaded for a read, provided the pins hold steady, and it also falls when the pins return to the levels captured at that read.
- R9: Every byte accepted after an address match is acknowledged. Read data is sent MSB first, and SDA changes only while SCL is low. A master NACK ends the read, and a repeated start begins a new transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the bus data line low |
| strap | input | STRAP_W | Low bits of the target address |
| pin_i | input | PORT_W | Pin levels seen at the pads |
| pin_o | output | PORT_W | Pin drive values (output register) |
| pin_oe | output | PORT_W | Pin drive enables, 1 = output |
| irq_oe | output | 1 | 1 pulls the active-low interrupt line low |

## Verification
The assertions assume that the master moves SDA only while SCL is low, except to form start and stop conditions. They also assume that SCL high and low phases last several system clocks, so the two-stage synchronisers see every level. The bench master holds each half bit for ten cycles and changes SDA two cycles after SCL falls. It changes pins only between bus transfers and waits for the synchronisers before it samples `irq_oe`. It never issues a start or stop while the target holds SDA low.

// File: rtl/xp_pkg.sv
package xp_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;

    typedef enum logic [1:0] {
        REG_IN  = 2'd0,
        REG_OUT = 2'd1,
        REG_POL = 2'd2,
        REG_CFG = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACKW,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_MACKF
    } bus_st_e;

    typedef enum logic [1:0] {
        RX_ADDR,
        RX_CMD,
        RX_DATA
    } rx_kind_e;
endpackage

// File: rtl/xp_sync.sv
module xp_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CHAIN_W = STAGES * W;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-W-1:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/xp_i2c_tgt.sv
module xp_i2c_tgt
    import xp_pkg::*;
#(
    parameter int                 STRAP_W = 3,
    parameter logic [6-STRAP_W:0] ADDR_HI = 4'b0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap,
    output logic               sda_oe,
    output logic               scl_s,
    output logic               wr_en,
    output logic [SEL_W-1:0]   wr_ptr,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               rd_take,
    output logic [SEL_W-1:0]   rd_ptr,
    input  logic [BYTE_W-1:0]  rd_data
);
    typedef struct packed {
        bus_st_e           st;
        rx_kind_e          kind;
        logic [BYTE_W-1:0] sh;
        logic [3:0]        cnt;
        logic              rw;
        logic [SEL_W-1:0]  ptr;
        logic              sda_oe;
        logic              scl_p;
        logic              sda_p;
    } tgt_t;

    localparam tgt_t TGT_RST = '{
        st: ST_IDLE, kind: RX_ADDR, sh: '0, cnt: '0, rw: 1'b0,
        ptr: '0, sda_oe: 1'b0, scl_p: 1'b1, sda_p: 1'b1
    };

    tgt_t              tgt_d, tgt_q;
    logic              sda_s;
    logic [6:0]        own_addr;
    logic [BYTE_W-1:0] byte_in;
    logic              scl_rise, scl_fall, bus_start, bus_stop;

    xp_sync #(.W(2), .STAGES(2), .RST(2'b11)) u_bus_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     ({scl_s, sda_s})
    );

    assign own_addr  = {ADDR_HI, strap};
    assign scl_rise  = scl_s & ~tgt_q.scl_p;
    assign scl_fall  = ~scl_s & tgt_q.scl_p;
    assign bus_start = scl_s & tgt_q.scl_p & tgt_q.sda_p & ~sda_s;
    assign bus_stop  = scl_s & tgt_q.scl_p & ~tgt_q.sda_p & sda_s;

    always_comb begin
        tgt_d       = tgt_q;
        tgt_d.scl_p = scl_s;
        tgt_d.sda_p = sda_s;
        byte_in     = {tgt_q.sh[BYTE_W-2:0], sda_s};
        wr_en       = 1'b0;
        wr_data     = byte_in;
        rd_take     = 1'b0;
        if (bus_start) begin
            tgt_d.st     = ST_RX;
            tgt_d.kind   = RX_ADDR;
            tgt_d.cnt    = '0;
            tgt_d.sda_oe = 1'b0;
        end else if (bus_stop) begin
            tgt_d.st     = ST_IDLE;
            tgt_d.sda_oe = 1'b0;
        end else begin
            case (tgt_q.st)
                ST_RX: if (scl_rise) begin
                    tgt_d.sh  = byte_in;
                    tgt_d.cnt = tgt_q.cnt + 4'd1;
                    if (tgt_q.cnt == 4'd7) begin
                        tgt_d.cnt = '0;
                        case (tgt_q.kind)
                            RX_ADDR: begin
                                if (byte_in[7:1] == own_addr) begin
                                    tgt_d.rw = byte_in[0];
                                    tgt_d.st = ST_ACKW;
                                end else begin
                                    tgt_d.st = ST_IDLE;
                                end
                            end
                            RX_CMD: begin
                                tgt_d.ptr = byte_in[SEL_W-1:0];
                                tgt_d.st  = ST_ACKW;
                            end
                            default: begin
                                wr_en    = 1'b1;
                                tgt_d.st = ST_ACKW;
                            end
                        endcase
                    end
                end
                ST_ACKW: if (scl_fall) begin
                    tgt_d.sda_oe = 1'b1;
                    tgt_d.st     = ST_ACK;
                end
                ST_ACK: if (scl_fall) begin
                    tgt_d.sda_oe = 1'b0;
                    tgt_d.cnt    = '0;
                    if (tgt_q.kind == RX_ADDR && tgt_q.rw) begin
                        rd_take      = 1'b1;
                        tgt_d.sh     = rd_data;
                        tgt_d.sda_oe = ~rd_data[BYTE_W-1];
                        tgt_d.st     = ST_TX;
                    end else begin
                        tgt_d.st   = ST_RX;
                        tgt_d.kind = (tgt_q.kind == RX_ADDR) ? RX_CMD : RX_DATA;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        tgt_d.cnt = tgt_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (tgt_q.cnt == 4'd8) begin
                            tgt_d.sda_oe = 1'b0;
                            tgt_d.st     = ST_MACK;
                        end else begin
                            tgt_d.sh     = {tgt_q.sh[BYTE_W-2:0], tgt_q.sh[BYTE_W-1]};
                            tgt_d.sda_oe = ~tgt_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: if (scl_rise) begin
                    tgt_d.st = sda_s ? ST_IDLE : ST_MACKF;
                end
                ST_MACKF: if (scl_fall) begin
                    rd_take      = 1'b1;
                    tgt_d.sh     = rd_data;
                    tgt_d.sda_oe = ~rd_data[BYTE_W-1];
                    tgt_d.cnt    = '0;
                    tgt_d.st     = ST_TX;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tgt_q <= TGT_RST;
        else        tgt_q <= tgt_d;
    end

    assign sda_oe = tgt_q.sda_oe;
    assign wr_ptr = tgt_q.ptr;
    assign rd_ptr = tgt_q.ptr;
endmodule

// File: rtl/xp_regfile.sv
module xp_regfile
    import xp_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_i,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_ptr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_take,
    input  logic [SEL_W-1:0]  rd_ptr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [PORT_W-1:0] pin_o,
    output logic [PORT_W-1:0] pin_oe,
    output logic              irq_oe,
    output logic [PORT_W-1:0] in_s,
    output logic [PORT_W-1:0] cfg_s
);
    localparam int ARM_MAX = SYNC_STAGES + 1;
    localparam int ARM_W   = $clog2(ARM_MAX + 1);

    typedef struct packed {
        logic [PORT_W-1:0] outr;
        logic [PORT_W-1:0] pol;
        logic [PORT_W-1:0] cfg;
        logic [PORT_W-1:0] snap;
        logic [ARM_W-1:0]  arm;
        logic              irq;
    } regs_t;

    localparam regs_t REGS_RST = '{
        outr: '1, pol: '0, cfg: '1, snap: '0, arm: '0, irq: 1'b0
    };

    regs_t regs_d, regs_q;
    logic  armed;

    xp_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .RST('0)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_i),
        .q     (in_s)
    );

    assign armed = (regs_q.arm == ARM_W'(ARM_MAX));

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (reg_sel_e'(wr_ptr))
                REG_OUT: regs_d.outr = wr_data[PORT_W-1:0];
                REG_POL: regs_d.pol  = wr_data[PORT_W-1:0];
                REG_CFG: regs_d.cfg  = wr_data[PORT_W-1:0];
                default: ;
            endcase
        end
        if (!armed) begin
            regs_d.arm  = regs_q.arm + 1'b1;
            regs_d.snap = in_s;
        end else if (rd_take && reg_sel_e'(rd_ptr) == REG_IN) begin
            regs_d.snap = in_s;
        end
        regs_d.irq = armed && |((in_s ^ regs_q.snap) & regs_q.cfg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_ptr))
            REG_IN:  rd_data[PORT_W-1:0] = in_s ^ regs_q.pol;
            REG_OUT: rd_data[PORT_W-1:0] = regs_q.outr;
            REG_POL: rd_data[PORT_W-1:0] = regs_q.pol;
            default: rd_data[PORT_W-1:0] = regs_q.cfg;
        endcase
    end

    assign pin_o  = regs_q.outr;
    assign pin_oe = ~regs_q.cfg;
    assign irq_oe = regs_q.irq;
    assign cfg_s  = regs_q.cfg;
endmodule

// File: rtl/i2c_gpio_xp.sv
module i2c_gpio_xp
    import xp_pkg::*;
#(
    parameter int                 PORT_W  = 8,
    parameter int                 STRAP_W = 3,
    parameter logic [6-STRAP_W:0] ADDR_HI = 4'b0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap,
    input  logic [PORT_W-1:0]  pin_i,
    output logic [PORT_W-1:0]  pin_o,
    output logic [PORT_W-1:0]  pin_oe,
    output logic               irq_oe
);
    logic              scl_s;
    logic              wr_en;
    logic [SEL_W-1:0]  wr_ptr;
    logic [BYTE_W-1:0] wr_data;
    logic              rd_take;
    logic [SEL_W-1:0]  rd_ptr;
    logic [BYTE_W-1:0] rd_data;
    logic [PORT_W-1:0] in_s;
    logic [PORT_W-1:0] cfg_s;

    xp_i2c_tgt #(.STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)) u_tgt (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .strap   (strap),
        .sda_oe  (sda_oe),
        .scl_s   (scl_s),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data),
        .rd_take (rd_take),
        .rd_ptr  (rd_ptr),
        .rd_data (rd_data)
    );

    xp_regfile #(.PORT_W(PORT_W), .SYNC_STAGES(2)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data),
        .rd_take (rd_take),
        .rd_ptr  (rd_ptr),
        .rd_data (rd_data),
        .pin_o   (pin_o),
        .pin_oe  (pin_oe),
        .irq_oe  (irq_oe),
        .in_s    (in_s),
        .cfg_s   (cfg_s)
    );
endmodule

// File: rtl/i2c_gpio_xp_chk.sv
module i2c_gpio_xp_chk #(
    parameter int PORT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              sda_oe,
    input logic              irq_oe,
    input logic [PORT_W-1:0] in_s,
    input logic [PORT_W-1:0] cfg_s,
    input logic              rd_take,
    input logic [1:0]        rd_ptr,
    input logic              wr_en,
    input logic [1:0]        wr_ptr,
    input logic [PORT_W-1:0] pin_o,
    input logic [PORT_W-1:0] pin_oe
);
    // R9
    sda_steady_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R4
    dir_change_after_cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_oe) |-> $past(wr_en && wr_ptr == 2'd3));

    // R6
    input_write_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr == 2'd0) |=> ($stable(pin_o) && $stable(pin_oe)));

    // R7
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_oe) |-> (($past(in_s, 1) != $past(in_s, 2)) ||
                           ($past(cfg_s, 1) != $past(cfg_s, 2))));

    // R8
    irq_clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && rd_ptr == 2'd0) ##1 $stable(in_s) |=> !irq_oe);
endmodule

bind i2c_gpio_xp i2c_gpio_xp_chk #(.PORT_W(PORT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .sda_oe  (sda_oe),
    .irq_oe  (irq_oe),
    .in_s    (in_s),
    .cfg_s   (cfg_s),
    .rd_take (rd_take),
    .rd_ptr  (rd_ptr),
    .wr_en   (wr_en),
    .wr_ptr  (wr_ptr),
    .pin_o   (pin_o),
    .pin_oe  (pin_oe)
);

// File: tb/i2c_gpio_xp_tb.sv
module i2c_gpio_xp_tb;
    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [2:0] strap = 3'b010;
    logic [7:0] pin_i = 8'h5A;
    logic [7:0] pin_o, pin_oe;
    logic       irq_oe;
    logic [6:0] dev_addr = {4'b0100, 3'b010};

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    logic [7:0] exp_q[$];
    string      req_q[$];
    logic [7:0] got_b;
    event       rd_ev;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_gpio_xp u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe),
        .strap  (strap),
        .pin_i  (pin_i),
        .pin_o  (pin_o),
        .pin_oe (pin_oe),
        .irq_oe (irq_oe)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; cyc(H);
        scl_m = 1'b1; cyc(H);
        sda_m = 1'b0; cyc(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        cyc(2); sda_m = 1'b0; cyc(H);
        scl_m = 1'b1; cyc(H);
        sda_m = 1'b1; cyc(H);
    endtask

    task automatic put_bit(logic b);
        cyc(2); sda_m = b; cyc(H);
        scl_m = 1'b1; cyc(H);
        scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        cyc(2); sda_m = 1'b1; cyc(H);
        scl_m = 1'b1; cyc(H/2);
        b = sda_bus; cyc(H/2);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(nack);
    endtask

    task automatic recv_byte(logic nack, output logic [7:0] b);
        logic bit_v;
        for (int i = 7; i >= 0; i--) begin
            get_bit(bit_v);
            b[i] = bit_v;
        end
        put_bit(nack);
    endtask

    // driver: write one or more data bytes to one register
    task automatic reg_write(logic [1:0] sel, logic [7:0] d0, int n, logic [7:0] d1, logic [7:0] d2);
        logic a;
        bus_start();
        send_byte({dev_addr, 1'b0}, a); chk("R9 addr ack", {7'd0, a}, 8'd0);
        send_byte({6'd0, sel}, a);      chk("R9 cmd ack", {7'd0, a}, 8'd0);
        send_byte(d0, a);               chk("R9 data ack", {7'd0, a}, 8'd0);
        if (n > 1) begin send_byte(d1, a); chk("R9 data ack", {7'd0, a}, 8'd0); end
        if (n > 2) begin send_byte(d2, a); chk("R9 data ack", {7'd0, a}, 8'd0); end
        bus_stop();
    endtask

    // driver: pointer write, repeated start, read n bytes; pushes expected values
    task automatic reg_read(logic [1:0] sel, logic [7:0] exp, int n, string req);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte({dev_addr, 1'b0}, a);
        send_byte({6'd0, sel}, a);
        bus_start();
        send_byte({dev_addr, 1'b1}, a); chk("R9 read addr ack", {7'd0, a}, 8'd0);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(exp);
            req_q.push_back(req);
            recv_byte(k == n - 1, b);
            got_b = b;
            -> rd_ev;
            cyc(1);
        end
        bus_stop();
    endtask

    // monitor: compare each read byte against the queued expectation
    initial begin
        forever begin
            logic [7:0] e;
            string r;
            @(rd_ev);
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", got_b, 8'hxx);
            end else begin
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(r, got_b, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog", 8'd0, 8'd1);
        finish_run();
    end

    initial begin
        logic a;
        cyc(5);
        // R1: reset state
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 irq", {7'd0, irq_oe}, 8'd0);
        chk("R1 sda", {7'd0, sda_oe}, 8'd0);
        rst_n = 1'b1;
        cyc(10);
        reg_read(2'd1, 8'hFF, 1, "R1 out reset");
        reg_read(2'd2, 8'h00, 1, "R1 pol reset");
        reg_read(2'd3, 8'hFF, 1, "R1 cfg reset");
        reg_read(2'd0, 8'h5A, 1, "R5 input plain");
        chk("R7 no change no irq", {7'd0, irq_oe}, 8'd0);

        // R3/R4: output value and direction
        reg_write(2'd1, 8'hA5, 1, 8'h00, 8'h00);
        chk("R4 pin_oe still inputs", pin_oe, 8'h00);
        reg_write(2'd3, 8'hF0, 1, 8'h00, 8'h00);
        chk("R4 pin_o", pin_o, 8'hA5);
        chk("R4 pin_oe", pin_oe, 8'h0F);
        reg_read(2'd1, 8'hA5, 1, "R3 out readback");
        reg_read(2'd3, 8'hF0, 1, "R3 cfg readback");

        // R5: inversion
        reg_write(2'd2, 8'h0F, 1, 8'h00, 8'h00);
        reg_read(2'd0, 8'h55, 1, "R5 input inverted");

        // R6: writes to input register ignored
        reg_write(2'd0, 8'hFF, 1, 8'h00, 8'h00);
        chk("R6 pin_o kept", pin_o, 8'hA5);
        chk("R6 pin_oe kept", pin_oe, 8'h0F);
        reg_read(2'd0, 8'h55, 1, "R6 input kept");
        reg_read(2'd2, 8'h0F, 1, "R6 pol kept");

        // R7: interrupt only from input-configured pins
        pin_i = 8'h5B; cyc(10);
        chk("R7 output pin no irq", {7'd0, irq_oe}, 8'd0);
        pin_i = 8'hDB; cyc(10);
        chk("R7 input pin irq", {7'd0, irq_oe}, 8'd1);
        // R8: cleared by reading the input register
        reg_read(2'd0, 8'hD4, 1, "R8 input on read");
        chk("R8 irq cleared by read", {7'd0, irq_oe}, 8'd0);
        pin_i = 8'h9B; cyc(10);
        chk("R7 irq again", {7'd0, irq_oe}, 8'd1);
        pin_i = 8'hDB; cyc(10);
        chk("R8 irq cleared by return", {7'd0, irq_oe}, 8'd0);

        // R2: wrong address ignored
        bus_start();
        send_byte({dev_addr ^ 7'h01, 1'b0}, a);
        chk("R2 wrong addr nack", {7'd0, a}, 8'd1);
        send_byte(8'h01, a);
        send_byte(8'h00, a);
        bus_stop();
        chk("R2 no write on mismatch", pin_o, 8'hA5);

        // R2: straps move the address
        strap = 3'b101; cyc(5);
        bus_start();
        send_byte({dev_addr, 1'b0}, a);
        chk("R2 old addr nack", {7'd0, a}, 8'd1);
        bus_stop();
        dev_addr = {4'b0100, 3'b101};
        reg_write(2'd1, 8'h3C, 1, 8'h00, 8'h00);
        chk("R2 new addr write", pin_o, 8'h3C);

        // R3/R9: multi-byte transfers keep the pointer
        reg_write(2'd1, 8'h11, 3, 8'h22, 8'h33);
        chk("R3 last of burst", pin_o, 8'h33);
        reg_read(2'd3, 8'hF0, 2, "R3 burst read");
        chk("R9 bus released", {7'd0, sda_oe}, 8'd0);

        cyc(20);
        finish_run();
    end
endmodule